// File: doc/BRIEF.md
# Display Status and Line Counter

This block produces the line and frame timing seen by one processor. It counts dot-clock ticks across a line, advances a line counter at the start of every line, and keeps three status flags: horizontal blank, vertical blank and line match. The line-match flag compares the line counter with a match value held in the status word. Each of the three conditions can raise a one-cycle interrupt pulse when its enable bit is set. The block also emits one-cycle DMA strobes on entry to horizontal blank (visible lines only) and on entry to vertical blank.

Timing advances only on cycles where `tick` is high, so the block can run from the system clock at any dot rate. Software reads the status word and may write it at any time. A write replaces the enable bits, the spare bit and the match value. The three flag bits are owned by the timing logic, and a write never changes them.

Top module: `dstat_timing`

## Requirements
- R1: While `rst_n` is low at a clock edge, the line counter, the whole status word and every pulse output are zero after that edge.
- R2: Status bit 1 (horizontal blank) is set by the tick that moves the dot column to `HBLANK_COL`. It is cleared by the tick that starts the next line, which is the tick that wraps the column from `LINE_TICKS-1` to 0.
- R3: At each line start the line counter goes up by one, and it wraps from `TOTAL_LINES-1` to 0.
- R4: At each line start, status bit 2 (match) is set if the new line number equals the 9-bit match field in status bits 15:7, and cleared otherwise.
- R5: `irq_match` pulses at a line start where the new line equals the match field, provided status bit 5 (match interrupt enable) is set.
- R6: Status bit 0 (vertical blank) is set when the line counter becomes `VISIBLE_LINES`, and cleared when it becomes `TOTAL_LINES-1`.
- R7: When the line counter becomes `VISIBLE_LINES`, `dma_vblank` pulses. In that same cycle `irq_vblank` pulses if status bit 3 (vertical blank interrupt enable) is set.
- R8: `irq_hblank` pulses at every horizontal blank start, on every line including blank lines, when status bit 4 (horizontal blank interrupt enable) is set.
- R9: `dma_hblank` pulses at horizontal blank start only while the line counter is below `VISIBLE_LINES`.
- R10: A status write stores write bits 15:3 into status bits 15:3, and bit 6 is a free read/write bit. Bits 2:0 keep their flag values whatever is written there.
- R11: Every interrupt and DMA output is high for exactly one clock cycle. On a cycle without `tick`, neither the column nor the line counter advances, and no flag or pulse changes because of timing.
- R12: When a status write lands in the same cycle as a line start, the flags follow the line start. That cycle's pulses use the enables and match value that were in place before the write, and the written value takes effect from the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Dot-clock enable; timing advances one column per high cycle |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 16 | Status write value; bits 2:0 are ignored |
| line_count | output | 9 | Current line number |
| status | output | 16 | {match[8:0], spare, match_ie, hblank_ie, vblank_ie, match, hblank, vblank} |
| irq_vblank | output | 1 | Vertical blank interrupt pulse |
| irq_hblank | output | 1 | Horizontal blank interrupt pulse |
| irq_match | output | 1 | Line match interrupt pulse |
| dma_vblank | output | 1 | Vertical blank DMA strobe |
| dma_hblank | output | 1 | Horizontal blank DMA strobe |

## Verification
The interesting collision is a software status write that lands on the same edge as a line start. Both update the status word, and the pulses of that edge depend on the enables and match value. The bench follows the column in its reference model. It then issues writes exactly on the line-start tick, changing the match value and the enables, sometimes to a value that would match the new line. It checks that the flags follow the timing, that the pulse follows the old settings, and that the new settings take effect on the next line. A second collision is vertical blank entry and line match on the same line start, which the bench provokes by programming the match field to the visible line count.

// File: rtl/dstat_pkg.sv
// Shared widths and status-word bit positions for the display status block.
// Assumes a frame of at most 512 lines (9-bit line number).
package dstat_pkg;
    localparam int LINE_W   = 9;
    localparam int STAT_W   = 16;
    localparam int FLAG_W   = 3;

    localparam int B_VBLANK   = 0;
    localparam int B_HBLANK   = 1;
    localparam int B_MATCH    = 2;
    localparam int B_VB_IE    = 3;
    localparam int B_HB_IE    = 4;
    localparam int B_MT_IE    = 5;
    localparam int MATCH_LSB  = 7;
    localparam int MATCH_MSB  = MATCH_LSB + LINE_W - 1;
endpackage

// File: rtl/dstat_dotcnt.sv
// Dot-column counter. Counts tick-qualified cycles across one line and flags
// the tick that enters horizontal blank and the tick that starts a new line.
// Assumes 0 < HBLANK_COL < LINE_TICKS.
module dstat_dotcnt #(
    parameter int LINE_TICKS = 355,
    parameter int HBLANK_COL = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic line_start_ev,
    output logic hblank_ev
);
    localparam int COL_W = $clog2(LINE_TICKS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_TICKS - 1);
    localparam logic [COL_W-1:0] PRE_HB   = COL_W'(HBLANK_COL - 1);

    logic [COL_W-1:0] col_q;

    // Advance the column on each tick, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (tick) begin
            col_q <= (col_q == LAST_COL) ? '0 : col_q + COL_W'(1);
        end
    end

    assign line_start_ev = tick && (col_q == LAST_COL);
    assign hblank_ev     = tick && (col_q == PRE_HB);

    // R11
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(col_q));

    // R2
    ev_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_ev |-> !hblank_ev);
endmodule

// File: rtl/dstat_linecnt.sv
// Line counter and vertical blank flag. Advances on each line start, wraps
// at the frame end, and reports entry into vertical blank.
// Assumes VISIBLE_LINES < TOTAL_LINES - 1 and TOTAL_LINES <= 512.
module dstat_linecnt
    import dstat_pkg::*;
#(
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_ev,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] next_line,
    output logic              vblank_q,
    output logic              vblank_enter
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_L     = LINE_W'(VISIBLE_LINES);

    assign next_line    = (line_q == LAST_LINE) ? '0 : line_q + LINE_W'(1);
    assign vblank_enter = line_start_ev && (next_line == VIS_L);

    // Step the line number and the vertical blank flag at each line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            vblank_q <= 1'b0;
        end else if (line_start_ev) begin
            line_q <= next_line;
            if (next_line == VIS_L) begin
                vblank_q <= 1'b1;
            end else if (next_line == LAST_LINE) begin
                vblank_q <= 1'b0;
            end
        end
    end

    // R3
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_ev && line_q == LAST_LINE) |=> (line_q == '0));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST_LINE);

    // R6
    vblank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank_q) |-> (line_q == LAST_LINE));
endmodule

// File: rtl/dstat_status.sv
// Status word, hblank and match flags, and the interrupt and DMA pulse
// registers. Software owns bits 15:3; timing owns bits 2:0. Pulse decisions
// use the settings held before a same-cycle write.
// Assumes line_start_ev and hblank_ev never coincide.
module dstat_status
    import dstat_pkg::*;
#(
    parameter int VISIBLE_LINES = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_ev,
    input  logic              hblank_ev,
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] next_line,
    input  logic              vblank_q,
    input  logic              vblank_enter,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq_vblank,
    output logic              irq_hblank,
    output logic              irq_match,
    output logic              dma_vblank,
    output logic              dma_hblank
);
    localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VISIBLE_LINES);

    logic [STAT_W-1:FLAG_W] ctrl_q;
    logic                   hblank_q;
    logic                   match_q;
    logic [LINE_W-1:0]      match_val;
    logic                   hit;
    logic                   unused_low;

    assign match_val  = ctrl_q[MATCH_MSB:MATCH_LSB];
    assign hit        = (next_line == match_val);
    assign unused_low = ^wr_data[FLAG_W-1:0];
    assign status     = {ctrl_q, match_q, hblank_q, vblank_q};

    // Software-owned control bits, replaced whole by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data[STAT_W-1:FLAG_W];
        end
    end

    // Horizontal blank and match flags, driven only by timing events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_q <= 1'b0;
            match_q  <= 1'b0;
        end else if (line_start_ev) begin
            hblank_q <= 1'b0;
            match_q  <= hit;
        end else if (hblank_ev) begin
            hblank_q <= 1'b1;
        end
    end

    // One-cycle interrupt and DMA pulses from the pre-write settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vblank <= 1'b0;
            irq_hblank <= 1'b0;
            irq_match  <= 1'b0;
            dma_vblank <= 1'b0;
            dma_hblank <= 1'b0;
        end else begin
            irq_vblank <= vblank_enter && ctrl_q[B_VB_IE];
            irq_hblank <= hblank_ev && ctrl_q[B_HB_IE];
            irq_match  <= line_start_ev && hit && ctrl_q[B_MT_IE];
            dma_vblank <= vblank_enter;
            dma_hblank <= hblank_ev && (line_q < VIS_L);
        end
    end

    // R10
    status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status[STAT_W-1:FLAG_W] == $past(wr_data[STAT_W-1:FLAG_W])));

    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !line_start_ev && !hblank_ev) |=>
            (status[FLAG_W-1:0] == $past(status[FLAG_W-1:0])));

    // R5
    match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> status[B_MATCH]);

    // R9
    hdma_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_hblank |-> (line_q < VIS_L));

    // R7
    vdma_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_vblank |-> (vblank_q && line_q == VIS_L));

    // R8
    hirq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |-> status[B_HBLANK]);

    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hblank || irq_vblank || irq_match) |=>
            !(irq_hblank && $past(irq_hblank)) && !(irq_vblank && $past(irq_vblank))
            && !(irq_match && $past(irq_match)));
endmodule

// File: rtl/dstat_timing.sv
// Top of the display status block: dot-column counter, line counter and
// status/pulse logic. One instance serves one processor view.
// Assumes 0 < HBLANK_COL < LINE_TICKS and VISIBLE_LINES < TOTAL_LINES-1 <= 511.
module dstat_timing
    import dstat_pkg::*;
#(
    parameter int LINE_TICKS    = 355,
    parameter int HBLANK_COL    = 256,
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              st_wr_en,
    input  logic [STAT_W-1:0] st_wr_data,
    output logic [LINE_W-1:0] line_count,
    output logic [STAT_W-1:0] status,
    output logic              irq_vblank,
    output logic              irq_hblank,
    output logic              irq_match,
    output logic              dma_vblank,
    output logic              dma_hblank
);
    logic              line_start_ev;
    logic              hblank_ev;
    logic [LINE_W-1:0] next_line;
    logic              vblank_q;
    logic              vblank_enter;

    dstat_dotcnt #(
        .LINE_TICKS (LINE_TICKS),
        .HBLANK_COL (HBLANK_COL)
    ) u_dot (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .line_start_ev (line_start_ev),
        .hblank_ev     (hblank_ev)
    );

    dstat_linecnt #(
        .VISIBLE_LINES (VISIBLE_LINES),
        .TOTAL_LINES   (TOTAL_LINES)
    ) u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start_ev (line_start_ev),
        .line_q        (line_count),
        .next_line     (next_line),
        .vblank_q      (vblank_q),
        .vblank_enter  (vblank_enter)
    );

    dstat_status #(
        .VISIBLE_LINES (VISIBLE_LINES)
    ) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start_ev (line_start_ev),
        .hblank_ev     (hblank_ev),
        .line_q        (line_count),
        .next_line     (next_line),
        .vblank_q      (vblank_q),
        .vblank_enter  (vblank_enter),
        .wr_en         (st_wr_en),
        .wr_data       (st_wr_data),
        .status        (status),
        .irq_vblank    (irq_vblank),
        .irq_hblank    (irq_hblank),
        .irq_match     (irq_match),
        .dma_vblank    (dma_vblank),
        .dma_hblank    (dma_hblank)
    );

    // R11
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_count));
endmodule

// File: tb/dstat_timing_bench.sv
module dstat_timing_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LT  = 8;
    localparam int HBC = 6;
    localparam int VIS = 6;
    localparam int TOT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [8:0]  line_count;
    logic [15:0] status;
    logic        irq_vblank, irq_hblank, irq_match, dma_vblank, dma_hblank;

    always #(CLK_PERIOD/2) clk = ~clk;

    dstat_timing #(
        .LINE_TICKS (LT),
        .HBLANK_COL (HBC),
        .VISIBLE_LINES (VIS),
        .TOTAL_LINES (TOT)
    ) u_dstat_timing (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .st_wr_en (wr_en), .st_wr_data (wr_data),
        .line_count (line_count), .status (status),
        .irq_vblank (irq_vblank), .irq_hblank (irq_hblank), .irq_match (irq_match),
        .dma_vblank (dma_vblank), .dma_hblank (dma_hblank)
    );

    typedef struct {
        logic [8:0]  line;
        logic [15:0] stat;
        logic        iv, ih, im, dv, dh;
        bit          rst;
        string       phase;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string phase = "";

    // reference state, built from the requirements
    int         m_col = 0;
    int         m_line = 0;
    bit         m_vb = 0, m_hb = 0, m_mt = 0;
    logic [15:3] m_ctrl = '0;

    task automatic step(input bit r, input bit t, input bit w, input logic [15:0] d);
        exp_t e;
        bit ls, hs;
        int nl;
        logic [8:0] mval;
        @(negedge clk);
        rst_n = r; tick = t; wr_en = w; wr_data = d;
        e.iv = 0; e.ih = 0; e.im = 0; e.dv = 0; e.dh = 0;
        e.rst = !r; e.phase = phase;
        if (!r) begin
            m_col = 0; m_line = 0; m_vb = 0; m_hb = 0; m_mt = 0; m_ctrl = '0;
        end else begin
            ls = t && (m_col == LT-1);
            hs = t && (m_col == HBC-1);
            mval = m_ctrl[15:7];
            nl = (m_line == TOT-1) ? 0 : m_line + 1;
            e.ih = hs && m_ctrl[4];
            e.dh = hs && (m_line < VIS);
            e.dv = ls && (nl == VIS);
            e.iv = e.dv && m_ctrl[3];
            e.im = ls && (9'(nl) == mval) && m_ctrl[5];
            if (t) m_col = (m_col == LT-1) ? 0 : m_col + 1;
            if (ls) begin
                m_line = nl; m_hb = 0; m_mt = (9'(nl) == mval);
                if (nl == VIS) m_vb = 1;
                else if (nl == TOT-1) m_vb = 0;
            end else if (hs) begin
                m_hb = 1;
            end
            if (w) m_ctrl = d[15:3];
        end
        e.line = 9'(m_line);
        e.stat = {m_ctrl, m_mt, m_hb, m_vb};
        q.push_back(e);
    endtask

    task automatic fld(input string req, input string ph, input int act, input int expv, inout bit bad);
        if (act != expv) begin
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, ph, act, expv);
            bad = 1;
        end
    endtask

    // monitor: pop and compare after each edge, away from it
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 0;
            vectors++;
            if (e.rst) begin
                fld("R1 line", e.phase, line_count, 0, bad);
                fld("R1 status", e.phase, status, 0, bad);
                fld("R1 pulses", e.phase, {irq_vblank, irq_hblank, irq_match, dma_vblank, dma_hblank}, 0, bad);
            end else begin
                fld("R3 line_count", e.phase, line_count, e.line, bad);
                fld("R6 vblank flag", e.phase, status[0], e.stat[0], bad);
                fld("R2 hblank flag", e.phase, status[1], e.stat[1], bad);
                fld("R4 match flag", e.phase, status[2], e.stat[2], bad);
                fld("R10 control bits", e.phase, status[15:3], e.stat[15:3], bad);
                fld("R8 irq_hblank", e.phase, irq_hblank, e.ih, bad);
                fld("R9 dma_hblank", e.phase, dma_hblank, e.dh, bad);
                fld("R7 dma_vblank", e.phase, dma_vblank, e.dv, bad);
                fld("R7 irq_vblank", e.phase, irq_vblank, e.iv, bad);
                fld("R5 irq_match", e.phase, irq_match, e.im, bad);
            end
            if (bad) miscompares++;
        end
    end

    function automatic logic [15:0] ctl(input int mv, input bit ve, input bit he, input bit me, input bit sp);
        return 16'((mv << 7) | (int'(sp) << 6) | (int'(me) << 5) | (int'(he) << 4) | (int'(ve) << 3));
    endfunction

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, '0);
    endtask

    // write exactly on the tick that starts a line
    task automatic write_at_line_start(input logic [15:0] d);
        while (m_col != LT-1) step(1, 1, 0, '0);
        step(1, 1, 1, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        phase = "R1 reset";
        for (int i = 0; i < 3; i++) step(0, 1, 1, 16'hFFFF);

        phase = "R10 write with low bits set";
        step(1, 0, 1, ctl(3, 1, 1, 1, 1) | 16'h0007);
        step(1, 0, 0, '0);

        phase = "R2 R3 R6 full frames";
        run(2 * LT * TOT + 5);

        phase = "R12 write at line start";
        write_at_line_start(ctl(5, 1, 0, 1, 0));
        run(LT * 3);
        write_at_line_start(ctl(int'(m_line == TOT-1 ? 0 : m_line + 1), 0, 1, 1, 1));
        run(LT * 2);
        write_at_line_start(ctl(2, 1, 1, 0, 0));
        run(LT * TOT);

        phase = "R7 R5 vblank entry with match";
        step(1, 1, 1, ctl(VIS, 1, 1, 1, 0));
        run(LT * TOT + 3);

        phase = "R3 R4 match at last line and zero";
        step(1, 1, 1, ctl(TOT-1, 0, 1, 1, 0));
        run(LT * TOT);
        step(1, 1, 1, ctl(0, 1, 0, 1, 0));
        run(LT * TOT);

        phase = "R4 match out of range";
        step(1, 1, 1, ctl(300, 1, 1, 1, 1));
        run(LT * TOT);

        phase = "R9 enables off, DMA continues";
        step(1, 1, 1, ctl(4, 0, 0, 0, 0));
        run(LT * TOT + 2);

        phase = "R11 sparse ticks";
        step(1, 0, 1, ctl(7, 1, 1, 1, 0));
        for (int i = 0; i < 3 * LT * TOT; i++) step(1, (i % 3) == 0, 0, '0);
        for (int i = 0; i < 2 * LT * TOT; i++) step(1, (i % 5) != 2, (i % 37) == 0, ctl(i % TOT, 1, 1, 1, 0) | 16'h0005);

        phase = "R1 reset again";
        step(0, 1, 0, '0);
        step(0, 0, 0, '0);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not end (actual=hung expected=finished)");
        finish_run();
    end
endmodule